// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into the oversampling strobe that a serial transmitter and receiver use to time their bits. The strobe is one clock wide. Its rate comes from a divisor word with an 18-bit integer part and a 6-bit binary fraction. When the clock is not a whole multiple of the wanted rate, the block dithers its period lengths so that the long-run average interval equals the fractional divisor. Software works out the divisor. It divides the system clock by the bit rate times the oversampling factor of 16 or 8, scales the result by 64 and rounds it. Software then writes the divisor as a single word.

Each interval is either the integer part or the integer part plus one clock. A 6-bit accumulator picks the longer interval whenever adding the fraction carries out of it. A write restarts the interval counter and the accumulator, so a new rate starts from a clean phase. An integer part of zero silences the strobe. After reset the block runs at a built-in divisor. That divisor is computed from parameters for 115200 bit/s with 16x oversampling on a 50 MHz clock, which gives 27 + 8/64.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, `tick` is 0. After reset the divisor is round(64·CLK_HZ/(BAUD·OVERSAMPLE)), which is integer 27 and fraction 8 at the default parameters. The schedule of R3 then runs from the last clock edge at which reset was high.
- R2: When the integer part is 2 or more, `tick` is never high in two consecutive cycles.
- R3: Count clock edges from the edge that takes the write (or the last reset edge) as edge 0. The N-th tick is high in the cycle after edge N·I + floor(N·F/64), where I = `scale_wdata[23:6]` and F = `scale_wdata[5:0]`. At no other edge is it high.
- R4: When I is nonzero, every interval between consecutive ticks is I or I+1 clocks.
- R5: When F is 0, every interval is exactly I clocks, and the accumulator never asks for a longer interval.
- R6: When I is 0, `tick` stays low until the next write.
- R7: A write in the middle of an interval discards the old phase. The first tick after the write follows exactly I edges later.
- R8: With I = 1 and F = 0, `tick` is high in every cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scale_we | input | 1 | One-cycle strobe that loads `scale_wdata` |
| scale_wdata | input | 24 | Divisor word: integer part in bits 23:6, fraction in bits 5:0 |
| tick | output | 1 | One-cycle oversampling strobe |

## Verification
The schedule is compared edge by edge against the closed-form tick positions. This is done for the post-reset default, for whole divisors (fraction 0, which shows the dither adds nothing), for fraction 32 (strict alternation) and fraction 63 (nearly every interval stretched), and for fixed-seed random divisors. The divisors 1.0 and 1.63 separate a strobe that is stuck high from one that really stretches an interval. A divisor of 0 shows that the strobe is silenced. A rewrite of the same divisor in mid-interval tells a design that restarts its phase from one that keeps the old count.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;
    localparam int INT_W   = 18;
    localparam int FRAC_W  = 6;
    localparam int SCALE_W = INT_W + FRAC_W;
    localparam int CNT_W   = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } scale_t;

    // Divisor in 1/2^FRAC_W units, rounded to nearest.
    function automatic scale_t calc_scale(longint clk_hz, longint baud, longint os);
        longint den;
        longint q;
        den = baud * os;
        q   = ((clk_hz << FRAC_W) + den / 2) / den;
        return scale_t'(q[SCALE_W-1:0]);
    endfunction
endpackage

// File: rtl/fbg_scale_reg.sv
`timescale 1ns/1ps
module fbg_scale_reg
    import fbg_pkg::*;
#(
    parameter scale_t RESET_SCALE = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  scale_t wr_scale,
    output scale_t scale_q,
    output scale_t load_scale
);
    assign load_scale = rst ? RESET_SCALE : wr_scale;

    always_ff @(posedge clk) begin
        if (rst || wr) scale_q <= load_scale;
    end
endmodule

// File: rtl/fbg_frac_accum.sv
`timescale 1ns/1ps
module fbg_frac_accum
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [FRAC_W-1:0] load_frac,
    input  logic [FRAC_W-1:0] frac,
    input  logic              period_end,
    output logic              stretch
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst || wr) begin
            // first interval already consumed one fraction step (0+F never carries)
            acc     <= load_frac;
            stretch <= 1'b0;
        end else if (period_end) begin
            acc     <= sum[FRAC_W-1:0];
            stretch <= sum[FRAC_W];
        end
    end

    // R5
    stretch_needs_frac_chk: assert property (@(posedge clk) disable iff (rst)
        stretch |-> (frac != '0));
endmodule

// File: rtl/fbg_period_cnt.sv
`timescale 1ns/1ps
module fbg_period_cnt
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [INT_W-1:0] ipart,
    input  logic             stretch,
    output logic             period_end,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit      = {1'b0, ipart} + CNT_W'(stretch);
    assign period_end = (ipart != '0) && (cnt == CNT_W'(limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || wr || ipart == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (period_end) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ipart > INT_W'(1)) |=> !tick);
    // R6
    zero_int_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (ipart == '0) |-> !tick);
    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (!tick && cnt == '0));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= {1'b0, ipart});
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int BAUD       = 115_200,
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scale_we,
    input  logic [SCALE_W-1:0] scale_wdata,
    output logic               tick
);
    localparam scale_t DEF_SCALE = calc_scale(longint'(CLK_HZ), longint'(BAUD),
                                              longint'(OVERSAMPLE));

    scale_t scale_q;
    scale_t load_scale;
    logic   stretch;
    logic   period_end;

    fbg_scale_reg #(.RESET_SCALE(DEF_SCALE)) u_scale (
        .clk        (clk),
        .rst        (rst),
        .wr         (scale_we),
        .wr_scale   (scale_t'(scale_wdata)),
        .scale_q    (scale_q),
        .load_scale (load_scale)
    );

    fbg_frac_accum u_accum (
        .clk        (clk),
        .rst        (rst),
        .wr         (scale_we),
        .load_frac  (load_scale.fpart),
        .frac       (scale_q.fpart),
        .period_end (period_end),
        .stretch    (stretch)
    );

    fbg_period_cnt u_cnt (
        .clk        (clk),
        .rst        (rst),
        .wr         (scale_we),
        .ipart      (scale_q.ipart),
        .stretch    (stretch),
        .period_end (period_end),
        .tick       (tick)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !tick);
endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scale_we = 1'b0;
    logic [23:0] scale_wdata = '0;
    logic        tick;

    int n_tests = 0;
    int n_fail  = 0;

    frac_baud_gen dut (.clk(clk), .rst(rst), .scale_we(scale_we),
                       .scale_wdata(scale_wdata), .tick(tick));

    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // edge index of the k-th tick after a restart (R3)
    function automatic int tick_edge(int k, int ip, int fp);
        return k * ip + (k * fp) / 64;
    endfunction

    task automatic run_case(input int ip, input int fp, input int ncyc,
                            input bit do_write, input string tag);
        int k, nxt, last, bad_sched, bad_gap, bad_pair, n_ticks, exp_ticks;
        bit prev;
        if (do_write) begin
            @(negedge clk);
            scale_we    = 1'b1;
            scale_wdata = {ip[17:0], fp[5:0]};
            @(posedge clk);
            #1 scale_we = 1'b0;
        end
        k = 1; nxt = tick_edge(1, ip, fp); last = 0; prev = 1'b0;
        bad_sched = 0; bad_gap = 0; bad_pair = 0; n_ticks = 0; exp_ticks = 0;
        for (int n = 1; n <= ncyc; n++) begin
            bit exp;
            @(posedge clk);
            #1;
            exp = (ip != 0) && (n == nxt);
            if (tick !== exp) bad_sched++;
            if (tick === 1'b1) n_ticks++;
            if (exp) begin
                exp_ticks++;
                if (last != 0 && ((n - last) < ip || (n - last) > ip + 1)) bad_gap++;
                if (last != 0 && fp == 0 && (n - last) != ip) bad_gap++;
                last = n;
                k++;
                nxt = tick_edge(k, ip, fp);
            end
            if (ip > 1 && tick === 1'b1 && prev) bad_pair++;
            prev = (tick === 1'b1);
        end
        check(tag, $sformatf("schedule mismatches I=%0d F=%0d", ip, fp), bad_sched, 0);
        check(tag, $sformatf("tick count I=%0d F=%0d", ip, fp), n_ticks, exp_ticks);
        check("R4", $sformatf("interval bound I=%0d F=%0d", ip, fp), bad_gap, 0);
        if (ip > 1) check("R2", $sformatf("back-to-back ticks I=%0d", ip), bad_pair, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1;
        check("R1", "tick during reset", int'(tick), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        // R1: default divisor 27 + 8/64
        run_case(27, 8, 600, 1'b0, "R1");

        run_case(2, 0, 200, 1'b1, "R5");
        run_case(9, 0, 300, 1'b1, "R5");
        run_case(3, 32, 300, 1'b1, "R3");
        run_case(5, 63, 500, 1'b1, "R3");
        run_case(1, 0, 100, 1'b1, "R8");
        run_case(1, 63, 300, 1'b1, "R3");
        run_case(0, 17, 200, 1'b1, "R6");

        // R7: rewrite mid-interval restarts the phase
        run_case(7, 20, 200, 1'b1, "R3");
        repeat (3) @(posedge clk);
        run_case(7, 20, 200, 1'b1, "R7");
        run_case(12, 5, 7, 1'b1, "R7");
        run_case(12, 5, 300, 1'b1, "R7");

        for (int r = 0; r < 20; r++) begin
            int ip, fp;
            ip = int'($urandom_range(40, 1));
            fp = int'($urandom_range(63, 0));
            run_case(ip, fp, 30 * ip + 80, 1'b1, "R3");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule